// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block collects interrupt requests from fifteen sources and presents one interrupt line and one 8-bit vector to a processor. Inside it, two identical eight-line controllers are chained. The secondary controller's interrupt output feeds line 2 of the primary controller. Each controller masks its requests and selects a trigger mode for each line. It picks one request by fixed priority, records acknowledged requests in an in-service set and clears them on end-of-interrupt commands.

Software reaches the block through a small register bus made of a 3-bit address, 8-bit write data and a write strobe. Every register reads back the last value written to it, including the command word, which would otherwise be write-only. The processor acknowledges with a one-cycle `inta` pulse. The vector for the granted line appears on `vector` one cycle later.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `int_out` and `vector` are 0. Every mask register reads 0xFF, and the trigger, base and command registers read 0.
- R2: Address bit 2 selects the controller (0 = primary, 1 = secondary). Address bits 1:0 select the mask (0), trigger (1), base (2) or command (3) register. A read returns the last value written, on `rdata`, one cycle after the address is presented.
- R3: A line whose mask bit is 1 raises no interrupt and is never granted. An edge latched while the line is masked is presented once the line is unmasked.
- R4: A line whose trigger bit is 0 is edge mode. A rising input is latched and stays pending after the input falls. The latch is cleared when that line is granted, and also when the line is switched to level mode.
- R5: A line whose trigger bit is 1 is level mode. It requests only while its input is high.
- R6: The fixed priority order, highest first, is primary lines 0 and 1, then secondary lines 0..7 (channels 8..15), then primary lines 3..7.
- R7: `int_out` is registered. An `inta` pulse while a request is presented sets the granted line's in-service bit. `vector` then becomes that controller's base plus the line number, modulo 256. `inta` with no request presented leaves `vector` unchanged.
- R8: The secondary controller's interrupt drives primary line 2. That line is always level-sensitive, is gated by primary mask bit 2, and ignores primary trigger bit 2. Input `irq[2]` has no effect. A grant through line 2 sets the in-service bits of both controllers.
- R9: While a line is in service, no request of equal or lower priority in the same controller is presented.
- R10: A write to a command register with bit 5 set clears that controller's highest-priority in-service bit. A secondary channel needs such a write to both controllers. A command write with bit 5 clear changes no request state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 16 | Request inputs; bits 7:0 primary, 15:8 secondary, bit 2 unused |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Registered read data |
| inta | input | 1 | Acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last granted line |

## Verification
The bench builds the block with its default parameters: eight lines per controller, 8-bit data and the cascade on primary line 2. With these values all fifteen channels and both vector bases are in reach. Directed sequences cover these cases:
- a lower primary line held off while a secondary channel is in service, until both controllers receive an end-of-interrupt;
- edge latches that outlive a falling input or a mask;
- the ignored `irq[2]` input.

Seeded random mixes of input changes, register writes, acknowledges and reads then run against a bench-side model of the priority and nesting rules.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_TRIG = 2'd1,
    REG_BASE = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;

  localparam int EOI_BIT = 5;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IW = $clog2(N);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int DW        = 8,
  parameter int CASC_EN   = 0,
  parameter int CASC_LINE = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LINES-1:0]         irq_i,
  input  logic                     casc_i,
  input  logic                     we_i,
  input  logic [1:0]               reg_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     ack_i,
  output logic [LINES-1:0]         mask_o,
  output logic [LINES-1:0]         trig_o,
  output logic [DW-1:0]            base_o,
  output logic [DW-1:0]            cmd_o,
  output logic                     int_o,
  output logic [$clog2(LINES)-1:0] pick_o
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] mask_q, trig_q, in_q, prev_q, latch_q, latch_d;
  logic [LINES-1:0] isr_q, isr_d, irr, req;
  logic [DW-1:0]    base_q, cmd_q;
  logic             p_found, s_found, ack_take, eoi;
  logic [IW-1:0]    p_idx, s_idx;
  logic             unused_in;

  assign unused_in = casc_i ^ in_q[CASC_LINE] ^ prev_q[CASC_LINE];

  // Per-line request source: cascade input, level input or edge latch
  for (genvar g = 0; g < LINES; g++) begin : g_line
    if (CASC_EN != 0 && g == CASC_LINE) begin : g_casc
      assign irr[g]     = casc_i;
      assign latch_d[g] = 1'b0;
    end else begin : g_norm
      assign irr[g]     = trig_q[g] ? in_q[g] : latch_q[g];
      assign latch_d[g] = trig_q[g] ? 1'b0 :
                          ((latch_q[g] && !(ack_take && p_idx == IW'(g))) ||
                           (in_q[g] && !prev_q[g]));
    end
  end

  assign req = irr & ~mask_q;

  pic_prio #(.N(LINES)) u_req_prio (
    .vec_i(req), .found_o(p_found), .idx_o(p_idx)
  );

  pic_prio #(.N(LINES)) u_isr_prio (
    .vec_i(isr_q), .found_o(s_found), .idx_o(s_idx)
  );

  assign int_o    = p_found && (!s_found || (p_idx < s_idx));
  assign ack_take = ack_i && int_o;
  assign eoi      = we_i && (reg_sel_e'(reg_i) == REG_CMD) && wdata_i[EOI_BIT];

  always_comb begin
    isr_d = isr_q;
    if (eoi && s_found) isr_d[s_idx] = 1'b0;
    if (ack_take)       isr_d[p_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      trig_q  <= '0;
      base_q  <= '0;
      cmd_q   <= '0;
      in_q    <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      isr_q   <= '0;
    end else begin
      in_q    <= irq_i;
      prev_q  <= in_q;
      latch_q <= latch_d;
      isr_q   <= isr_d;
      if (we_i) begin
        case (reg_sel_e'(reg_i))
          REG_MASK: mask_q <= wdata_i[LINES-1:0];
          REG_TRIG: trig_q <= wdata_i[LINES-1:0];
          REG_BASE: base_q <= wdata_i;
          default:  cmd_q  <= wdata_i;
        endcase
      end
    end
  end

  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign base_o = base_q;
  assign cmd_o  = cmd_q;
  assign pick_o = p_idx;

  AST_ISR_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack_take |=> ((isr_q & ~$past(isr_q)) == '0)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> ($countones(isr_q & ~$past(isr_q)) == 1)); // R7
  AST_ACK_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> ((isr_q & ~$past(isr_q) & $past(mask_q)) == '0)); // R3
  AST_EOI_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack_take && (isr_q != '0)) |=>
      ($countones($past(isr_q)) - $countones(isr_q) == 1)); // R10
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*LINES-1:0] irq,
  input  logic [2:0]         addr,
  input  logic [DW-1:0]      wdata,
  input  logic               we,
  output logic [DW-1:0]      rdata,
  input  logic               inta,
  output logic               int_out,
  output logic [DW-1:0]      vector
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] m_mask, m_trig, s_mask, s_trig;
  logic [DW-1:0]    m_base, m_cmd, s_base, s_cmd;
  logic             m_int, s_int, m_we, s_we, m_ack, s_ack;
  logic [IW-1:0]    m_pick, s_pick;

  assign m_we  = we && !addr[2];
  assign s_we  = we &&  addr[2];
  assign m_ack = inta && m_int;
  assign s_ack = m_ack && (m_pick == IW'(CASC_LINE));

  pic_unit #(.LINES(LINES), .DW(DW), .CASC_EN(1), .CASC_LINE(CASC_LINE)) u_primary (
    .clk(clk), .rst(rst), .irq_i(irq[LINES-1:0]), .casc_i(s_int),
    .we_i(m_we), .reg_i(addr[1:0]), .wdata_i(wdata), .ack_i(m_ack),
    .mask_o(m_mask), .trig_o(m_trig), .base_o(m_base), .cmd_o(m_cmd),
    .int_o(m_int), .pick_o(m_pick)
  );

  pic_unit #(.LINES(LINES), .DW(DW), .CASC_EN(0), .CASC_LINE(CASC_LINE)) u_secondary (
    .clk(clk), .rst(rst), .irq_i(irq[2*LINES-1:LINES]), .casc_i(1'b0),
    .we_i(s_we), .reg_i(addr[1:0]), .wdata_i(wdata), .ack_i(s_ack),
    .mask_o(s_mask), .trig_o(s_trig), .base_o(s_base), .cmd_o(s_cmd),
    .int_o(s_int), .pick_o(s_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      int_out <= 1'b0;
      vector  <= '0;
    end else begin
      int_out <= m_int;
      case ({addr[2], addr[1:0]})
        3'd0:    rdata <= DW'(m_mask);
        3'd1:    rdata <= DW'(m_trig);
        3'd2:    rdata <= m_base;
        3'd3:    rdata <= m_cmd;
        3'd4:    rdata <= DW'(s_mask);
        3'd5:    rdata <= DW'(s_trig);
        3'd6:    rdata <= s_base;
        default: rdata <= s_cmd;
      endcase
      if (m_ack) begin
        if (s_ack) vector <= s_base + DW'(s_pick);
        else       vector <= m_base + DW'(m_pick);
      end
    end
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inta |=> $stable(vector)); // R7
  AST_SEC_GRANT_NEEDS_INT: assert property (@(posedge clk) disable iff (rst)
    s_ack |-> s_int); // R8
endmodule

// File: tb/pic_cascade_test.sv
module pic_cascade_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq = '0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        inta = 1'b0;
  logic [7:0]  rdata, vector;
  logic        int_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mask = 8'hFF, s_mask = 8'hFF, m_trig = 0, s_trig = 0;
  logic [7:0] m_base = 0, s_base = 0, m_cmd = 0, s_cmd = 0;
  logic [7:0] m_isr = 0, s_isr = 0, m_lat = 0, s_lat = 0, exp_vec = 0;

  pic_cascade uut (
    .clk(clk), .rst(rst), .irq(irq), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .inta(inta), .int_out(int_out), .vector(vector)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic unit_int(logic [7:0] req, logic [7:0] isr);
    int p, s;
    p = lowest(req);
    s = lowest(isr);
    return (p < 8) && (p < s);
  endfunction

  function automatic logic [7:0] s_req_f();
    return ~s_mask & ((s_trig & irq[15:8]) | s_lat);
  endfunction

  function automatic logic [7:0] m_req_f();
    logic [7:0] raw;
    raw = (m_trig & irq[7:0]) | m_lat;
    raw[2] = unit_int(s_req_f(), s_isr);
    return raw & ~m_mask;
  endfunction

  function automatic logic m_int_f();
    return unit_int(m_req_f(), m_isr);
  endfunction

  function automatic logic [7:0] model_reg(logic [2:0] a);
    case (a)
      3'd0: return m_mask;
      3'd1: return m_trig;
      3'd2: return m_base;
      3'd3: return m_cmd;
      3'd4: return s_mask;
      3'd5: return s_trig;
      3'd6: return s_base;
      default: return s_cmd;
    endcase
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_int(string r);
    chk(r, int_out, m_int_f());
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string r);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd0: m_mask = d;
      3'd1: begin m_trig = d; m_lat &= ~d; end
      3'd2: m_base = d;
      3'd3: begin m_cmd = d; if (d[5] && lowest(m_isr) < 8) m_isr[lowest(m_isr)] = 1'b0; end
      3'd4: s_mask = d;
      3'd5: begin s_trig = d; s_lat &= ~d; end
      3'd6: s_base = d;
      default: begin s_cmd = d; if (d[5] && lowest(s_isr) < 8) s_isr[lowest(s_isr)] = 1'b0; end
    endcase
    settle(3);
    check_int(r);
  endtask

  task automatic rd(logic [2:0] a, string r);
    @(negedge clk);
    addr = a;
    settle(2);
    chk(r, rdata, model_reg(a));
  endtask

  task automatic set_irq(logic [15:0] nv, string r);
    logic [15:0] rises;
    @(negedge clk);
    rises = nv & ~irq;
    irq = nv;
    m_lat |= rises[7:0] & ~m_trig & 8'hFB;
    s_lat |= rises[15:8] & ~s_trig;
    settle(4);
    check_int(r);
  endtask

  task automatic ack(string r);
    int p, ps;
    if (m_int_f()) begin
      p = lowest(m_req_f());
      if (p == 2) begin
        ps = lowest(s_req_f());
        s_isr[ps] = 1'b1;
        s_lat[ps] = 1'b0;
        exp_vec = s_base + 8'(ps);
      end else begin
        m_lat[p] = 1'b0;
        exp_vec = m_base + 8'(p);
      end
      m_isr[p] = 1'b1;
    end
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk(r, vector, exp_vec);
    settle(3);
    check_int(r);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    settle(3);
    rst = 1'b0;
    settle(2);
    // R1: reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 vector", vector, 0);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset value");

    // R2: shadow readback
    wr(3'd2, 8'h40, "R2"); wr(3'd6, 8'h70, "R2");
    wr(3'd3, 8'h11, "R10 no eoi"); wr(3'd7, 8'h0C, "R10 no eoi");
    for (int a = 0; a < 8; a++) rd(3'(a), "R2 readback");
    wr(3'd0, 8'h00, "R3"); wr(3'd4, 8'h00, "R3");

    // R8: irq[2] ignored
    set_irq(16'h0004, "R8 irq2 ignored");
    chk("R8 irq2 literal", int_out, 0);

    // R4: edge latch holds after fall, cleared on grant
    set_irq(16'h0008, "R4 edge rise");
    chk("R4 edge literal", int_out, 1);
    set_irq(16'h0000, "R4 held after fall");
    ack("R7 vector line3");
    chk("R7 vector literal", vector, 8'h43);
    wr(3'd3, 8'h20, "R10 eoi");
    chk("R4 latch cleared", int_out, 0);

    // R5: level mode
    wr(3'd1, 8'h20, "R5");
    set_irq(16'h0020, "R5 level high");
    chk("R5 level literal", int_out, 1);
    set_irq(16'h0000, "R5 level low");
    chk("R5 level drop", int_out, 0);

    // R6 / R9 / R10: ordering and nesting through cascade
    set_irq(16'h0182, "R6");
    ack("R6 line1 first");
    chk("R6 literal", vector, 8'h41);
    wr(3'd3, 8'h20, "R10");
    ack("R6 secondary before line7");
    chk("R8 secondary vector", vector, 8'h70);
    chk("R9 line7 blocked", int_out, 0);
    wr(3'd7, 8'h20, "R10 secondary only");
    chk("R10 primary still in service", int_out, 0);
    wr(3'd3, 8'h20, "R10 primary eoi");
    chk("R10 line7 released", int_out, 1);
    ack("R6 line7");
    chk("R6 line7 literal", vector, 8'h47);
    wr(3'd3, 8'h20, "R10");
    set_irq(16'h0000, "R4");

    // R3: masked edge latched, presented after unmask
    wr(3'd0, 8'h01, "R3");
    set_irq(16'h0001, "R3 masked");
    chk("R3 masked literal", int_out, 0);
    ack("R7 spurious inta");
    chk("R7 vector held", vector, 8'h47);
    wr(3'd0, 8'h00, "R3 unmask");
    chk("R3 unmasked literal", int_out, 1);
    ack("R7");
    wr(3'd3, 8'h20, "R10");

    // random mix
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) set_irq(16'($urandom()), "R4 R5 R6 random irq");
      else if (op < 5) ack("R7 R9 random ack");
      else if (op < 7) begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 1)) << 2 | 3'd3;
        wr(a, $urandom_range(0, 1) ? 8'h20 : 8'($urandom()) & 8'hDF, "R10 random cmd");
      end else if (op < 9) begin
        logic [2:0] a;
        logic [7:0] d;
        a = 3'($urandom_range(0, 7));
        d = 8'($urandom());
        if (a[1:0] == 2'd0) d &= 8'($urandom());
        wr(a, d, "R3 R8 random write");
      end else rd(3'($urandom_range(0, 7)), "R2 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule